// File: doc/BRIEF.md
# Operand Override Buffer

This block sits beside the operand-fetch stage of a small accumulator core. Two override instructions arm a one-shot operand buffer. The register form captures the value that its own operand fetch returns. The literal form captures the constant field of its own opcode. The next issued instruction then takes its operand from the buffer and not from the register file. After that one slot the override lapses.

A companion instruction class writes its operand to a file register and updates no flags. Paired with an override, it copies a register or a constant into another register and leaves the working register (W) and STATUS alone. This makes the pair safe in interrupt handlers that save neither of them. The block also decodes, for each instruction class, which of the register-file, W and STATUS write strobes fire. The core's ALU computes the values that are written.

An instruction that falls in a skipped slot arms nothing and writes nothing. Reset clears a pending override, and so does entry to an interrupt.

Top module: `operand_override`

## Requirements
- R1: After a synchronous reset, `ovr_active` is 0 and `opnd` equals `rd_data`.
- R2: An issued, unskipped register override (`op_class`=1) loads the buffer with that slot's `opnd`. In the next cycle `ovr_active` is 1 and `opnd` shows the captured value, whatever `rd_data` is.
- R3: An issued, unskipped literal override (`op_class`=2) loads `lit` into the buffer. In the next cycle `ovr_active` is 1 and `opnd` equals that literal.
- R4: A pending override serves exactly one following issued slot. In the cycle after that slot, `ovr_active` is 0 and `opnd` follows `rd_data` again, unless the slot was itself an override that re-armed the buffer.
- R5: When `issue` is low, a pending override and its value are held unchanged.
- R6: An override issued with `skip`=1 arms nothing. A pending override lapses in an issued slot even when that slot is skipped.
- R7: Both override classes leave `reg_we`, `w_we` and `flg_we` all at 0.
- R8: The move-without-flags class (`op_class`=3) asserts `reg_we` only. `w_we` and `flg_we` stay 0.
- R9: Write strobes by class. Class 4 (register result with flags) asserts `reg_we` and `flg_we`. Class 5 (W result with flags) asserts `w_we` and `flg_we`. Class 6 (W to register) asserts `reg_we`. Classes 0 (no-op) and 7 (test) assert none. No strobe fires when `issue` is 0 or `skip` is 1.
- R10: `irq_entry` clears a pending override in the next cycle. It also wins over an override issued in the same cycle.
- R11: A register override issued while another override is pending captures the buffered value, not `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An instruction occupies this slot |
| op_class | input | 3 | Decoded instruction class |
| lit | input | DW | Literal field of the current opcode |
| rd_data | input | DW | Register-file read data for this slot |
| skip | input | 1 | The current slot is skipped |
| irq_entry | input | 1 | Interrupt entry is taken this cycle |
| opnd | output | DW | Effective operand for this slot |
| ovr_active | output | 1 | The buffer replaces this slot's operand fetch |
| reg_we | output | 1 | Register-file write strobe |
| w_we | output | 1 | W write strobe |
| flg_we | output | 1 | STATUS flag write strobe |

## Verification
The assertions check the following on every cycle:
- arming after an unskipped override, and the captured literal value;
- one-shot lapse after a serving slot;
- no arming from a skipped slot;
- holding while idle;
- clearing on interrupt entry;
- the write-strobe rules for override, move-without-flags and skipped slots.

Only the bench scenarios show the operand that is actually delivered. These cover the chained register override, the full strobe table, and a counter that decrements to zero and reloads a constant through a literal override and a move without flags. In that counter loop, W and STATUS keep their values throughout.

// File: rtl/oob_pkg.sv
package oob_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OPC_NOP     = 3'd0,
    OPC_OVR_REG = 3'd1,
    OPC_OVR_LIT = 3'd2,
    OPC_REG_NF  = 3'd3,
    OPC_REG_FL  = 3'd4,
    OPC_W_FL    = 3'd5,
    OPC_W2REG   = 3'd6,
    OPC_TEST    = 3'd7
  } op_class_e;

  typedef struct packed {
    logic reg_we;
    logic w_we;
    logic flg_we;
  } wr_strobe_t;
endpackage

// File: rtl/oob_decode.sv
module oob_decode
  import oob_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           issue,
  input  logic           skip,
  input  logic [OPW-1:0] op_class,
  output wr_strobe_t     strobe,
  output logic           arm_reg,
  output logic           arm_lit
);
  logic       live;
  wr_strobe_t raw;

  assign live = issue && !skip;

  always_comb begin
    raw = '0;
    unique case (op_class_e'(op_class))
      OPC_REG_NF: raw.reg_we = 1'b1;
      OPC_REG_FL: begin raw.reg_we = 1'b1; raw.flg_we = 1'b1; end
      OPC_W_FL:   begin raw.w_we   = 1'b1; raw.flg_we = 1'b1; end
      OPC_W2REG:  raw.reg_we = 1'b1;
      default:    raw = '0;
    endcase
  end

  assign strobe  = live ? raw : '0;
  assign arm_reg = live && (op_class == OPC_OVR_REG);
  assign arm_lit = live && (op_class == OPC_OVR_LIT);

  a_r7_override_writes_nothing: assert property (@(posedge clk) disable iff (rst)
    (issue && (op_class == OPC_OVR_REG || op_class == OPC_OVR_LIT)) |-> (strobe == '0));
  a_r8_move_nf_no_flags: assert property (@(posedge clk) disable iff (rst)
    (op_class == OPC_REG_NF) |-> (!strobe.flg_we && !strobe.w_we));
  a_r9_skipped_slot_quiet: assert property (@(posedge clk) disable iff (rst)
    (skip || !issue) |-> (strobe == '0 && !arm_reg && !arm_lit));
endmodule

// File: rtl/oob_buffer.sv
module oob_buffer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_entry,
  input  logic          issue,
  input  logic          arm_reg,
  input  logic          arm_lit,
  input  logic [DW-1:0] lit,
  input  logic [DW-1:0] cap_val,
  output logic          pending,
  output logic [DW-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      held    <= '0;
    end else if (irq_entry) begin
      pending <= 1'b0;
    end else if (issue) begin
      if (arm_reg || arm_lit) begin
        pending <= 1'b1;
        held    <= arm_lit ? lit : cap_val;
      end else begin
        pending <= 1'b0;
      end
    end
  end

  a_r2_arm_on_override: assert property (@(posedge clk) disable iff (rst)
    (issue && (arm_reg || arm_lit) && !irq_entry) |=> pending);
  a_r3_literal_captured: assert property (@(posedge clk) disable iff (rst)
    (issue && arm_lit && !irq_entry) |=> (held == $past(lit)));
  a_r4_one_shot: assert property (@(posedge clk) disable iff (rst)
    (issue && pending && !arm_reg && !arm_lit) |=> !pending);
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (pending && !issue && !irq_entry) |=> (pending && $stable(held)));
  a_r6_no_arm_from_idle: assert property (@(posedge clk) disable iff (rst)
    (!pending && !(issue && (arm_reg || arm_lit))) |=> !pending);
  a_r10_irq_clears: assert property (@(posedge clk) disable iff (rst)
    irq_entry |=> !pending);
endmodule

// File: rtl/oob_opmux.sv
module oob_opmux #(
  parameter int DW = 8
) (
  input  logic          pending,
  input  logic [DW-1:0] held,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] opnd
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign opnd[b] = pending ? held[b] : rd_data[b];
  end
endmodule

// File: rtl/operand_override.sv
module operand_override
  import oob_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue,
  input  logic [OPW-1:0] op_class,
  input  logic [DW-1:0]  lit,
  input  logic [DW-1:0]  rd_data,
  input  logic           skip,
  input  logic           irq_entry,
  output logic [DW-1:0]  opnd,
  output logic           ovr_active,
  output logic           reg_we,
  output logic           w_we,
  output logic           flg_we
);
  wr_strobe_t    strobe;
  logic          arm_reg;
  logic          arm_lit;
  logic          pending;
  logic [DW-1:0] held;

  oob_decode u_decode (
    .clk(clk), .rst(rst), .issue(issue), .skip(skip), .op_class(op_class),
    .strobe(strobe), .arm_reg(arm_reg), .arm_lit(arm_lit)
  );

  oob_buffer #(.DW(DW)) u_buffer (
    .clk(clk), .rst(rst), .irq_entry(irq_entry), .issue(issue),
    .arm_reg(arm_reg), .arm_lit(arm_lit), .lit(lit), .cap_val(opnd),
    .pending(pending), .held(held)
  );

  oob_opmux #(.DW(DW)) u_opmux (
    .pending(pending), .held(held), .rd_data(rd_data), .opnd(opnd)
  );

  assign ovr_active = pending;
  assign reg_we     = strobe.reg_we;
  assign w_we       = strobe.w_we;
  assign flg_we     = strobe.flg_we;

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!ovr_active && opnd == rd_data));
endmodule

// File: tb/operand_override_tb.sv
module operand_override_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          issue = 1'b0;
  logic [2:0]    op_class = 3'd0;
  logic [DW-1:0] lit = '0;
  logic [DW-1:0] rd_data = '0;
  logic          skip = 1'b0;
  logic          irq_entry = 1'b0;
  logic [DW-1:0] opnd;
  logic          ovr_active, reg_we, w_we, flg_we;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  operand_override #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .issue(issue), .op_class(op_class), .lit(lit),
    .rd_data(rd_data), .skip(skip), .irq_entry(irq_entry), .opnd(opnd),
    .ovr_active(ovr_active), .reg_we(reg_we), .w_we(w_we), .flg_we(flg_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one slot after the falling edge; outputs settle before the next rise.
  task automatic put(input logic iss, input logic [2:0] oc, input logic [DW-1:0] l,
                     input logic [DW-1:0] rd, input logic sk, input logic irq);
    @(negedge clk);
    issue = iss; op_class = oc; lit = l; rd_data = rd; skip = sk; irq_entry = irq;
    #2;
  endtask

  task automatic idle(input logic [DW-1:0] rd);
    put(1'b0, 3'd0, 8'h00, rd, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    idle(8'h11); idle(8'h11);
    rst = 1'b0;
    idle(8'h37);
    check("R1 ovr_active", ovr_active, 0);
    check("R1 opnd", opnd, 8'h37);
  endtask

  task automatic t_force_reg;
    put(1'b1, 3'd1, 8'hFF, 8'hA5, 1'b0, 1'b0);
    check("R7 reg-override strobes", {reg_we, w_we, flg_we}, 0);
    put(1'b1, 3'd3, 8'h00, 8'h12, 1'b0, 1'b0);
    check("R2 ovr_active", ovr_active, 1);
    check("R2 opnd", opnd, 8'hA5);
    check("R8 move-nf strobes", {reg_we, w_we, flg_we}, 3'b100);
    idle(8'h66);
    check("R4 lapsed", ovr_active, 0);
    check("R4 opnd back", opnd, 8'h66);
  endtask

  task automatic t_force_lit_idle;
    put(1'b1, 3'd2, 8'h28, 8'h99, 1'b0, 1'b0);
    check("R7 lit-override strobes", {reg_we, w_we, flg_we}, 0);
    idle(8'h01); idle(8'h02); idle(8'h03);
    check("R5 held pending", ovr_active, 1);
    check("R5 held value", opnd, 8'h28);
    put(1'b1, 3'd4, 8'h00, 8'h04, 1'b0, 1'b0);
    check("R3 literal used", opnd, 8'h28);
    idle(8'h05);
    check("R4 lapsed after lit", ovr_active, 0);
  endtask

  task automatic t_skip;
    put(1'b1, 3'd2, 8'h77, 8'h10, 1'b1, 1'b0);
    idle(8'h20);
    check("R6 skipped override no arm", ovr_active, 0);
    check("R6 normal operand", opnd, 8'h20);
    put(1'b1, 3'd2, 8'h44, 8'h10, 1'b0, 1'b0);
    put(1'b1, 3'd3, 8'h00, 8'h30, 1'b1, 1'b0);
    check("R6 skipped slot strobes", {reg_we, w_we, flg_we}, 0);
    idle(8'h31);
    check("R6 skipped slot consumes", ovr_active, 0);
  endtask

  task automatic t_decode;
    logic [2:0] exp [8] = '{3'b000, 3'b000, 3'b000, 3'b100, 3'b101, 3'b011, 3'b100, 3'b000};
    for (int c = 0; c < 8; c++) begin
      put(1'b1, 3'(c), 8'h00, 8'h00, 1'b0, 1'b0);
      check($sformatf("R9 class %0d strobes", c), {reg_we, w_we, flg_we}, exp[c]);
    end
    put(1'b0, 3'd4, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R9 no issue strobes", {reg_we, w_we, flg_we}, 0);
    idle(8'h00);
  endtask

  task automatic t_irq;
    put(1'b1, 3'd2, 8'h55, 8'h00, 1'b0, 1'b0);
    put(1'b0, 3'd0, 8'h00, 8'h01, 1'b0, 1'b1);
    check("R10 pending before irq", ovr_active, 1);
    idle(8'h02);
    check("R10 cleared", ovr_active, 0);
    put(1'b1, 3'd2, 8'h56, 8'h00, 1'b0, 1'b1);
    idle(8'h03);
    check("R10 irq wins over arm", ovr_active, 0);
    check("R10 opnd", opnd, 8'h03);
  endtask

  task automatic t_chain;
    put(1'b1, 3'd2, 8'hC3, 8'h00, 1'b0, 1'b0);
    put(1'b1, 3'd1, 8'h00, 8'h5E, 1'b0, 1'b0);
    put(1'b1, 3'd3, 8'h00, 8'h7F, 1'b0, 1'b0);
    check("R11 chained active", ovr_active, 1);
    check("R11 chained value", opnd, 8'hC3);
    idle(8'h00);
  endtask

  // Bench model of the core around the block: counter register, W and STATUS.
  task automatic t_counter_reload;
    logic [DW-1:0] ctr, w_reg, status;
    logic [DW-1:0] exp_ctr [3] = '{8'd1, 8'd40, 8'd39};
    logic zero;
    ctr = 8'd2; w_reg = 8'h5A; status = 8'h03;
    for (int it = 0; it < 3; it++) begin
      // decrement, skip next if zero (register write, no flags)
      put(1'b1, 3'd3, 8'h00, ctr, 1'b0, 1'b0);
      zero = ((opnd - 8'd1) == 0);
      if (reg_we) ctr = opnd - 8'd1;
      if (w_we) w_reg = 8'hEE;
      if (flg_we) status = 8'hEE;
      // test of an always-clear bit: skipped when zero, else skips next
      put(1'b1, 3'd7, 8'h00, 8'h00, zero, 1'b0);
      // literal override 40, skipped unless counter reached zero
      put(1'b1, 3'd2, 8'd40, 8'h00, !zero, 1'b0);
      if (w_we) w_reg = 8'hEE;
      if (flg_we) status = 8'hEE;
      // move without flags into counter
      put(1'b1, 3'd3, 8'h00, ctr, 1'b0, 1'b0);
      if (reg_we) ctr = opnd;
      if (w_we) w_reg = 8'hEE;
      if (flg_we) status = 8'hEE;
      check($sformatf("R3 R8 counter iter %0d", it), ctr, exp_ctr[it]);
    end
    check("R8 W untouched", w_reg, 8'h5A);
    check("R8 STATUS untouched", status, 8'h03);
    idle(8'h00);
  endtask

  initial begin
    t_reset();
    t_force_reg();
    t_force_lit_idle();
    t_skip();
    t_decode();
    t_irq();
    t_chain();
    t_counter_reload();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule